// File: doc/BRIEF.md
# Chunk-Threshold Audio Sample FIFO Flags

The block holds one receive FIFO and one transmit FIFO of audio samples for each of four DSP lanes. Each lane owns a 3-bit chunk code in a shared 32-bit configuration word. The code selects a burst size of 1, 2, 4, 8 or 16 samples.

A receive flag tells a DMA engine that a full chunk of unread samples is waiting. A transmit flag tells it that a full chunk of free slots can be filled. Each flag also gives a one-cycle trigger pulse when it rises, which a DMA channel can use to start one burst.

The configuration word is written through a simple write port. A write-protect input blocks that port while it is high. Samples enter and leave each FIFO through valid/ready handshakes. The DMA engine and the sample-rate arithmetic sit outside the block.

Top module: `audio_chunk_fifo_flags`

## Requirements
- R1: After reset all chunk codes are 0 (1-sample chunk), every FIFO is empty, every receive flag is low, every transmit flag is high, every push ready is high and every pop valid is low.
- R2: Lane n takes its chunk code from configuration bits [16+4n+2 : 16+4n], so lane 0 uses 18:16, lane 1 uses 22:20, lane 2 uses 26:24 and lane 3 uses 30:28. Codes 0, 1, 2, 3 and 4 select chunks of 1, 2, 4, 8 and 16 samples. All other configuration bits have no effect.
- R3: Codes 5, 6 and 7 act as a 16-sample chunk.
- R4: A lane's receive flag is high exactly when its receive FIFO holds at least the chunk number of samples.
- R5: A lane's transmit flag is high exactly when its transmit FIFO has at least the chunk number of free slots, where free slots are 32 minus the stored count.
- R6: Each trigger output is high for exactly one cycle. That cycle comes right after the cycle in which its flag goes from low to high, and the trigger stays low otherwise.
- R7: A configuration write while write-protect is high leaves every chunk code unchanged. With write-protect low, the written word takes effect on the next clock edge.
- R8: Each FIFO returns samples in push order and holds 32 entries. Push ready is low when the FIFO is full and a push offered then is dropped. Pop valid is low when the FIFO is empty.
- R9: A push and a pop accepted in the same cycle on one FIFO both take effect and leave the stored count, and so the flag, unchanged.
- R10: Lanes are independent: traffic or a chunk code on one lane does not change another lane's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write-protect enable; blocks writes when high |
| cfg_wdata | input | 32 | Configuration word to write |
| rx_push_vld | input | 4 | Receive FIFO push valid, one bit per lane |
| rx_push_data | input | 64 | Receive push samples, lane n at bits 16n+15:16n |
| rx_push_rdy | output | 4 | Receive FIFO not full |
| rx_pop_rdy | input | 4 | Receive FIFO pop request |
| rx_pop_vld | output | 4 | Receive FIFO not empty |
| rx_pop_data | output | 64 | Oldest receive sample per lane |
| tx_push_vld | input | 4 | Transmit FIFO push valid |
| tx_push_data | input | 64 | Transmit push samples |
| tx_push_rdy | output | 4 | Transmit FIFO not full |
| tx_pop_rdy | input | 4 | Transmit FIFO pop request |
| tx_pop_vld | output | 4 | Transmit FIFO not empty |
| tx_pop_data | output | 64 | Oldest transmit sample per lane |
| rx_chunk_flag | output | 4 | Receive chunk available per lane |
| tx_chunk_flag | output | 4 | Transmit chunk space per lane |
| rx_dma_trig | output | 4 | One-cycle pulse after a receive flag rises |
| tx_dma_trig | output | 4 | One-cycle pulse after a transmit flag rises |

## Verification
A push and a pop can land on the same FIFO in the same cycle. The count then has to stay put, the flag must not toggle, and no trigger may fire. The bench provokes this on a receive FIFO that sits at its threshold. It judges the result by the flag, by the absence of a trigger and by the scoreboard order of the popped samples.

A configuration write can also land in a cycle where a flag moves. The bench judges this case through the flag value the new threshold predicts, with write-protect both set and clear.

// File: rtl/acf_pkg.sv
package acf_pkg;
   localparam int CODE_W   = 3;
   localparam int MAX_CODE = 4;

   // Chunk length in samples for a code; codes above MAX_CODE saturate.
   function automatic int unsigned chunk_len(input logic [CODE_W-1:0] code);
      if (code > CODE_W'(MAX_CODE))
         return 32'd1 << MAX_CODE;
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/acf_cfg.sv
module acf_cfg #(
   parameter int LANES  = 4,
   parameter int WORD_W = 32,
   parameter int BASE   = 16,
   parameter int STRIDE = 4,
   localparam int CW    = acf_pkg::CODE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic                  wp,
   input  logic [WORD_W-1:0]     wdata,
   output logic [LANES*CW-1:0]   codes
);
   if (BASE + (LANES - 1) * STRIDE + CW > WORD_W) begin : g_bad_layout
      $error("acf_cfg: chunk fields exceed the configuration word");
   end
   if (STRIDE < CW) begin : g_bad_stride
      $error("acf_cfg: fields overlap");
   end

   logic load;
   assign load = we && !wp;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [CW-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q <= '0;
         else if (load)
            code_q <= wdata[BASE + ln*STRIDE +: CW];
      end
      assign codes[ln*CW +: CW] = code_q;
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   // R7: a protected write leaves the codes untouched
   a_r7_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wp) |=> $stable(codes));
endmodule

// File: rtl/acf_fifo.sv
module acf_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_vld,
   input  logic [DW-1:0] push_data,
   output logic          push_rdy,
   input  logic          pop_rdy,
   output logic          pop_vld,
   output logic [DW-1:0] pop_data,
   output logic [LW-1:0] level
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("acf_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] level_q;
   logic          push_fire, pop_fire;

   assign push_rdy  = (level_q != LW'(DEPTH));
   assign pop_vld   = (level_q != '0);
   assign push_fire = push_vld && push_rdy;
   assign pop_fire  = pop_rdy && pop_vld;
   assign pop_data  = mem[rd_ptr];
   assign level     = level_q;

   always_ff @(posedge clk) begin
      if (push_fire)
         mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push_fire) wr_ptr <= wr_ptr + 1'b1;
         if (pop_fire)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_fire, pop_fire})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
      end
   end

   // R8: a push offered to a full FIFO without a pop does not change the level
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && !push_rdy && !pop_fire) |=> (level == $past(level)));
   // R8: popping an empty FIFO is refused
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_vld && !push_vld) |=> (level == '0));
   // R9: simultaneous push and pop keep the level
   a_r9_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (push_fire && pop_fire) |=> (level == $past(level)));
endmodule

// File: rtl/acf_chunk_flag.sv
module acf_chunk_flag #(
   parameter int DEPTH      = 32,
   parameter bit FREE_SLOTS = 1'b0,
   localparam int LW        = $clog2(DEPTH + 1),
   localparam int CW        = acf_pkg::CODE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [CW-1:0] code,
   output logic          flag,
   output logic          trig
);
   if (DEPTH < (1 << acf_pkg::MAX_CODE)) begin : g_too_shallow
      $error("acf_chunk_flag: DEPTH must hold the largest chunk");
   end

   logic [LW-1:0] thr, metric;
   logic          flag_q, trig_q;

   assign thr = LW'(acf_pkg::chunk_len(code));

   if (FREE_SLOTS) begin : g_free
      assign metric = LW'(DEPTH) - level;
   end else begin : g_used
      assign metric = level;
   end

   assign flag = (metric >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         flag_q <= flag;
         trig_q <= flag && !flag_q;
      end
   end
   assign trig = trig_q;

   // R6: trigger lasts one cycle
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);
   // R6: a flag rise is followed by a trigger
   a_r6_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |=> trig);
endmodule

// File: rtl/audio_chunk_fifo_flags.sv
module audio_chunk_fifo_flags #(
   parameter int LANES  = 4,
   parameter int DW     = 16,
   parameter int DEPTH  = 32,
   parameter int WORD_W = 32,
   parameter int BASE   = 16,
   parameter int STRIDE = 4,
   localparam int CW    = acf_pkg::CODE_W,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_wp,
   input  logic [WORD_W-1:0]   cfg_wdata,
   input  logic [LANES-1:0]    rx_push_vld,
   input  logic [LANES*DW-1:0] rx_push_data,
   output logic [LANES-1:0]    rx_push_rdy,
   input  logic [LANES-1:0]    rx_pop_rdy,
   output logic [LANES-1:0]    rx_pop_vld,
   output logic [LANES*DW-1:0] rx_pop_data,
   input  logic [LANES-1:0]    tx_push_vld,
   input  logic [LANES*DW-1:0] tx_push_data,
   output logic [LANES-1:0]    tx_push_rdy,
   input  logic [LANES-1:0]    tx_pop_rdy,
   output logic [LANES-1:0]    tx_pop_vld,
   output logic [LANES*DW-1:0] tx_pop_data,
   output logic [LANES-1:0]    rx_chunk_flag,
   output logic [LANES-1:0]    tx_chunk_flag,
   output logic [LANES-1:0]    rx_dma_trig,
   output logic [LANES-1:0]    tx_dma_trig
);
   logic [LANES*CW-1:0] codes;

   acf_cfg #(.LANES(LANES), .WORD_W(WORD_W), .BASE(BASE), .STRIDE(STRIDE)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wp(cfg_wp),
      .wdata(cfg_wdata), .codes(codes));

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [LW-1:0] rx_level, tx_level;

      acf_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_fifo_i (
         .clk(clk), .rst_n(rst_n),
         .push_vld(rx_push_vld[ln]), .push_data(rx_push_data[ln*DW +: DW]),
         .push_rdy(rx_push_rdy[ln]),
         .pop_rdy(rx_pop_rdy[ln]), .pop_vld(rx_pop_vld[ln]),
         .pop_data(rx_pop_data[ln*DW +: DW]), .level(rx_level));

      acf_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_fifo_i (
         .clk(clk), .rst_n(rst_n),
         .push_vld(tx_push_vld[ln]), .push_data(tx_push_data[ln*DW +: DW]),
         .push_rdy(tx_push_rdy[ln]),
         .pop_rdy(tx_pop_rdy[ln]), .pop_vld(tx_pop_vld[ln]),
         .pop_data(tx_pop_data[ln*DW +: DW]), .level(tx_level));

      acf_chunk_flag #(.DEPTH(DEPTH), .FREE_SLOTS(1'b0)) rx_flag_i (
         .clk(clk), .rst_n(rst_n), .level(rx_level),
         .code(codes[ln*CW +: CW]),
         .flag(rx_chunk_flag[ln]), .trig(rx_dma_trig[ln]));

      acf_chunk_flag #(.DEPTH(DEPTH), .FREE_SLOTS(1'b1)) tx_flag_i (
         .clk(clk), .rst_n(rst_n), .level(tx_level),
         .code(codes[ln*CW +: CW]),
         .flag(tx_chunk_flag[ln]), .trig(tx_dma_trig[ln]));

      // R5: a full transmit FIFO never reports chunk space
      a_r5_full_no_space: assert property (@(posedge clk) disable iff (!rst_n)
         !tx_push_rdy[ln] |-> !tx_chunk_flag[ln]);
      // R4: an empty receive FIFO never reports a chunk
      a_r4_empty_no_chunk: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_pop_vld[ln] |-> !rx_chunk_flag[ln]);
   end
endmodule

// File: tb/audio_chunk_fifo_flags_tb_top.sv
module audio_chunk_fifo_flags_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int L  = 4;
   localparam int DW = 16;
   localparam int D  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_wp = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [L-1:0] rx_push_vld = '0, rx_pop_rdy = '0, tx_push_vld = '0, tx_pop_rdy = '0;
   logic [L*DW-1:0] rx_push_data = '0, tx_push_data = '0;
   logic [L-1:0] rx_push_rdy, rx_pop_vld, tx_push_rdy, tx_pop_vld;
   logic [L*DW-1:0] rx_pop_data, tx_pop_data;
   logic [L-1:0] rx_chunk_flag, tx_chunk_flag, rx_dma_trig, tx_dma_trig;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_chunk_fifo_flags dut_i (.*);

   int checks = 0, failures = 0;
   int rx_cnt[L], tx_cnt[L], chk[L], new_chk[L];
   bit cfg_pend = 0;
   logic [DW-1:0] rxq[L][$];
   logic [DW-1:0] txq[L][$];
   logic [L-1:0] cur_rx, cur_tx, h1_rx, h1_tx, h2_rx, h2_tx;
   logic [DW-1:0] seq = 16'h1000;

   function automatic int code_len(input int code);
      return (code > 4) ? 16 : (1 << code);
   endfunction

   task automatic check(input string tag, input int lane, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s lane %0d %s act=%0h exp=%0h", tag, lane, what, act, exp);
      end
   endtask

   function automatic void compute_flags();
      for (int l = 0; l < L; l++) begin
         cur_rx[l] = (rx_cnt[l] >= chk[l]);
         cur_tx[l] = ((D - tx_cnt[l]) >= chk[l]);
      end
   endfunction

   task automatic check_flags(input string tag);
      for (int l = 0; l < L; l++) begin
         check(tag, l, "rx_flag", rx_chunk_flag[l], cur_rx[l]);
         check(tag, l, "tx_flag", tx_chunk_flag[l], cur_tx[l]);
         check("R6", l, "rx_trig", rx_dma_trig[l], h1_rx[l] & ~h2_rx[l]);
         check("R6", l, "tx_trig", tx_dma_trig[l], h1_tx[l] & ~h2_tx[l]);
      end
   endtask

   // Driver + scoreboard: one clock cycle of traffic with per-lane masks
   task automatic cycle(input logic [L-1:0] rp, input logic [L-1:0] rq,
                        input logic [L-1:0] tp, input logic [L-1:0] tq,
                        input string tag);
      bit rx_acc[L], tx_acc[L], rx_pop[L], tx_pop[L];
      logic [DW-1:0] rdat[L], tdat[L];
      for (int l = 0; l < L; l++) begin
         rdat[l] = seq; seq++;
         tdat[l] = seq; seq++;
         rx_push_data[l*DW +: DW] = rdat[l];
         tx_push_data[l*DW +: DW] = tdat[l];
         rx_acc[l] = rp[l] && (rx_cnt[l] < D);
         tx_acc[l] = tp[l] && (tx_cnt[l] < D);
         rx_pop[l] = rq[l] && (rx_cnt[l] > 0);
         tx_pop[l] = tq[l] && (tx_cnt[l] > 0);
         if (rp[l]) check("R8", l, "rx_push_rdy", rx_push_rdy[l], rx_cnt[l] < D);
         if (tp[l]) check("R8", l, "tx_push_rdy", tx_push_rdy[l], tx_cnt[l] < D);
         if (rq[l]) begin
            check("R8", l, "rx_pop_vld", rx_pop_vld[l], rx_cnt[l] > 0);
            if (rx_pop[l]) check("R8", l, "rx_data", rx_pop_data[l*DW +: DW], rxq[l][0]);
         end
         if (tq[l]) begin
            check("R8", l, "tx_pop_vld", tx_pop_vld[l], tx_cnt[l] > 0);
            if (tx_pop[l]) check("R8", l, "tx_data", tx_pop_data[l*DW +: DW], txq[l][0]);
         end
      end
      rx_push_vld = rp; rx_pop_rdy = rq; tx_push_vld = tp; tx_pop_rdy = tq;
      @(posedge clk);
      for (int l = 0; l < L; l++) begin
         if (rx_pop[l]) begin void'(rxq[l].pop_front()); rx_cnt[l]--; end
         if (tx_pop[l]) begin void'(txq[l].pop_front()); tx_cnt[l]--; end
         if (rx_acc[l]) begin rxq[l].push_back(rdat[l]); rx_cnt[l]++; end
         if (tx_acc[l]) begin txq[l].push_back(tdat[l]); tx_cnt[l]++; end
         if (cfg_pend) chk[l] = new_chk[l];
      end
      cfg_pend = 0;
      h2_rx = h1_rx; h2_tx = h1_tx; h1_rx = cur_rx; h1_tx = cur_tx;
      compute_flags();
      @(negedge clk);
      rx_push_vld = '0; rx_pop_rdy = '0; tx_push_vld = '0; tx_pop_rdy = '0;
      cfg_we = 1'b0; cfg_wp = 1'b0;
      check_flags(tag);
   endtask

   task automatic cfg_write(input logic [31:0] w, input logic prot, input string tag);
      cfg_we = 1'b1; cfg_wp = prot; cfg_wdata = w;
      if (!prot) begin
         cfg_pend = 1;
         for (int l = 0; l < L; l++) new_chk[l] = code_len(int'(w[16 + 4*l +: 3]));
      end
      cycle('0, '0, '0, '0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int l = 0; l < L; l++) begin
         rx_cnt[l] = 0; tx_cnt[l] = 0; chk[l] = 1; new_chk[l] = 1;
      end
      compute_flags();
      h1_rx = '0; h1_tx = '0; h2_rx = '0; h2_tx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int l = 0; l < L; l++) begin
         check("R1", l, "rx_flag", rx_chunk_flag[l], 0);
         check("R1", l, "tx_flag", tx_chunk_flag[l], 1);
         check("R1", l, "rx_push_rdy", rx_push_rdy[l], 1);
         check("R1", l, "rx_pop_vld", rx_pop_vld[l], 0);
         check("R1", l, "tx_pop_vld", tx_pop_vld[l], 0);
      end
      // R6: transmit triggers fire once after reset, then stay low
      cycle('0, '0, '0, '0, "R6");
      cycle('0, '0, '0, '0, "R6");
      // R4: chunk of 1 on lane 0 only (R10: other lanes stay low)
      cycle(4'b0001, '0, '0, '0, "R4");
      cycle('0, '0, '0, '0, "R6");
      cycle('0, 4'b0001, '0, '0, "R8");
      // R2/R3: lane codes 2,3,4,6 with stray bits set outside fields
      cfg_write(32'h6432_0000 | 32'h0088_FFFF, 1'b0, "R2");
      for (int i = 0; i < 17; i++) cycle(4'hF, '0, '0, '0, "R3");
      for (int i = 0; i < 17; i++) cycle('0, 4'hF, '0, '0, "R4");
      // R5: fill transmit FIFOs past full, then drain past empty
      for (int i = 0; i < 34; i++) cycle('0, '0, 4'hF, '0, "R5");
      for (int i = 0; i < 34; i++) cycle('0, '0, '0, 4'hF, "R5");
      // R10: one lane's transmit traffic alone
      for (int i = 0; i < 20; i++) cycle('0, '0, 4'b0100, '0, "R10");
      for (int i = 0; i < 20; i++) cycle('0, '0, '0, 4'b0100, "R10");
      // R7: protected write is ignored; lane 0 keeps chunk 4
      cfg_write(32'h0000_0000, 1'b1, "R7");
      cycle(4'b0001, '0, '0, '0, "R7");
      cfg_write(32'h0000_0000, 1'b0, "R7");
      // R9: simultaneous push and pop on lane 0 receive at threshold
      for (int i = 0; i < 6; i++) cycle(4'b0001, 4'b0001, '0, '0, "R9");
      for (int l = 0; l < L; l++)
         check("R9", l, "rx_pop_vld", rx_pop_vld[l], rx_cnt[l] > 0);
      for (int i = 0; i < 3; i++) cycle('0, 4'b0001, '0, '0, "R9");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule